// File: doc/BRIEF.md
# Condition-Code Arithmetic and Logic Unit

This block is a 32-bit arithmetic and logic unit that keeps a four-bit condition-code register holding negative (N), zero (Z), overflow (V) and carry/borrow (C). It adds, adds with the stored carry, subtracts, and forms bitwise AND, OR and XOR of two operands. The result is combinational and appears in the same cycle as the operands. The condition codes are registered and can drive a branch decision unit on the following cycle.

Each operation has two forms. A flag-updating form is selected by raising `set_flags` with `en`. A plain form leaves the condition codes untouched. The usual idioms are built from the flag-updating forms with the result ignored: compare is a flagged subtract, test is a flagged OR against zero, and bit-test is a flagged AND. On subtraction, C holds the unsigned borrow rather than an inverted carry. The extended add consumes C, so a 64-bit sum is formed by a flagged add of the low words followed by a flagged extended add of the high words.

There is no sequencing state. The only storage is the flag register, which has two transitions. LOAD captures new flags when `en`, `set_flags` and a defined operation code coincide. HOLD keeps the stored flags in every other cycle.

Top module: `ccalu`

## Requirements
- R1: While `rst_n` is low, and at the first sampling after it, `flags` reads 4'b0000 (bit order {N,Z,V,C} = bits 3..0).
- R2: Operation code 3'd0 (add) gives `result` = src_a + src_b modulo 2^32. Its flagged form sets C to the carry out of bit 31.
- R3: Operation code 3'd1 (extended add) gives `result` = src_a + src_b + C, where C is the stored flag. A flagged add of the low words followed by a flagged extended add of the high words yields the exact 64-bit sum, and C then holds the 65th bit.
- R4: Operation code 3'd2 (subtract) gives `result` = src_a - src_b modulo 2^32. Its flagged form sets C to 1 exactly when src_a < src_b unsigned.
- R5: For flagged add, extended add and subtract, V is 1 exactly when the signed mathematical result lies outside [-2^31, 2^31-1].
- R6: Every flagged operation with a defined code sets N to bit 31 of `result` and sets Z to 1 exactly when `result` is zero.
- R7: Codes 3'd3, 3'd4 and 3'd5 give AND, OR and XOR of the operands. Their flagged forms clear V and C.
- R8: Flags change only at a rising clock edge where `en` and `set_flags` are both 1. In every other cycle they keep their value, while `result` still follows the operands.
- R9: Codes 3'd6 and 3'd7 give `result` = 0 and never change the flags, even when `en` and `set_flags` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| en | input | 1 | Clock enable for the flag register |
| set_flags | input | 1 | Selects the flag-updating form |
| op_sel | input | 3 | Operation code (0 add, 1 extended add, 2 subtract, 3 AND, 4 OR, 5 XOR, 6/7 reserved) |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| result | output | 32 | Combinational result |
| flags | output | 4 | Registered condition codes {N,Z,V,C} |

## Verification
The assertions check on every cycle that N and Z track the result that was loaded, that a flagged subtract leaves the unsigned borrow in C, that flagged logic operations clear V and C, and that flags hold unless an update is enabled on a defined code. Only the bench scenarios can show the numerical correctness of the sums and the signed-overflow decision across operand sign combinations. The same holds for the carry chaining of the extended add into a correct 64-bit total, since that spans two operations and depends on the stored carry.

// File: rtl/ccalu_pkg.sv
package ccalu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDX = 3'd1,
        OP_SUB  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        LG_AND  = 2'd0,
        LG_OR   = 2'd1,
        LG_XOR  = 2'd2,
        LG_ZERO = 2'd3
    } logic_sel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

endpackage

// File: rtl/ccalu_addsub.sv
module ccalu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             subtract,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_flag,
    output logic             ovf
);
    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0]   wide;
    logic [WIDTH-1:0] b_eff;
    logic             cin_eff;

    always_comb begin
        b_eff   = subtract ? ~b : b;
        cin_eff = subtract ? 1'b1 : carry_in;
        wide    = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_eff};
        sum     = wide[WIDTH-1:0];
        // on subtract the adder carry means "no borrow"; report the borrow instead
        carry_flag = subtract ? ~wide[WIDTH] : wide[WIDTH];
        ovf     = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
    end

endmodule

// File: rtl/ccalu_logic.sv
module ccalu_logic
    import ccalu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_sel_e       sel,
    output logic [WIDTH-1:0] y
);

    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            LG_ZERO: y = '0;
        endcase
    end

endmodule

// File: rtl/ccalu_flagreg.sv
module ccalu_flagreg
    import ccalu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  cc_t  d,
    output cc_t  q
);

    typedef enum logic {ST_HOLD = 1'b0, ST_LOAD = 1'b1} fr_state_e;

    fr_state_e action;

    always_comb begin
        action = load ? ST_LOAD : ST_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (action)
                ST_LOAD: q <= d;
                ST_HOLD: q <= q;
            endcase
        end
    end

endmodule

// File: rtl/ccalu.sv
module ccalu
    import ccalu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             set_flags,
    input  logic [2:0]       op_sel,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    output logic [WIDTH-1:0] result,
    output logic [3:0]       flags
);
    localparam int MSB = WIDTH - 1;

    op_e        op;
    cc_t        cc_q;
    cc_t        cc_d;
    logic_sel_e lsel;
    logic       is_sub;
    logic       use_carry;
    logic       is_arith;
    logic       op_valid;
    logic       load;
    logic [WIDTH-1:0] as_sum;
    logic [WIDTH-1:0] lg_y;
    logic             as_c;
    logic             as_v;

    assign op = op_e'(op_sel);

    always_comb begin
        is_sub    = 1'b0;
        use_carry = 1'b0;
        is_arith  = 1'b0;
        op_valid  = 1'b1;
        lsel      = LG_ZERO;
        unique case (op)
            OP_ADD:  is_arith = 1'b1;
            OP_ADDX: begin is_arith = 1'b1; use_carry = 1'b1; end
            OP_SUB:  begin is_arith = 1'b1; is_sub = 1'b1; end
            OP_AND:  lsel = LG_AND;
            OP_OR:   lsel = LG_OR;
            OP_XOR:  lsel = LG_XOR;
            OP_RSV6, OP_RSV7: op_valid = 1'b0;
        endcase
    end

    ccalu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a          (src_a),
        .b          (src_b),
        .subtract   (is_sub),
        .carry_in   (use_carry & cc_q.c),
        .sum        (as_sum),
        .carry_flag (as_c),
        .ovf        (as_v)
    );

    ccalu_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (src_a),
        .b   (src_b),
        .sel (lsel),
        .y   (lg_y)
    );

    always_comb begin
        result  = is_arith ? as_sum : lg_y;
        cc_d.n  = result[MSB];
        cc_d.z  = (result == '0);
        cc_d.v  = is_arith & as_v;
        cc_d.c  = is_arith & as_c;
        load    = en & set_flags & op_valid;
    end

    ccalu_flagreg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (cc_d),
        .q     (cc_q)
    );

    assign flags = cc_q;

    AST_NEG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && set_flags && op_sel < 3'd6) |=> flags[3] == $past(result[MSB])); // R6
    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && set_flags && op_sel < 3'd6) |=> flags[2] == ($past(result) == '0)); // R6
    AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (en && set_flags && op_sel == 3'd2) |=> flags[0] == ($past(src_a) < $past(src_b))); // R4
    AST_LOGIC_CLEARS_VC: assert property (@(posedge clk) disable iff (!rst_n)
        (en && set_flags && op_sel >= 3'd3 && op_sel <= 3'd5) |=> flags[1:0] == 2'b00); // R7
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && set_flags) |=> $stable(flags)); // R8
    AST_RSV_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 3'd6) |=> $stable(flags)); // R9
    AST_RSV_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 3'd6) |-> result == '0); // R9

endmodule

// File: tb/ccalu_tb_top.sv
module ccalu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVAL = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        set_flags = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] result;
    logic [3:0]  flags;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;
    logic [3:0] mflags = 4'b0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccalu dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .set_flags(set_flags),
        .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
        .result(result), .flags(flags)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] corner(input int i);
        case (i)
            0: return 32'h0000_0000;  1: return 32'h0000_0001;
            2: return 32'h0000_0002;  3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;  5: return 32'h8000_0001;
            6: return 32'hFFFF_FFFF;  7: return 32'hFFFF_FFFE;
            8: return 32'h5555_5555;  9: return 32'hAAAA_AAAA;
            10: return 32'h1234_5678; default: return 32'hFFFF_0000;
        endcase
    endfunction

    function automatic void model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                                  input logic cin, output logic [31:0] r,
                                  output logic v, output logic c, output bit valid);
        longint sa, sb, rs;
        logic [32:0] w;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        valid = 1'b1; v = 1'b0; c = 1'b0; r = '0; rs = 0;
        case (op)
            3'd0: begin w = {1'b0,a} + {1'b0,b}; r = w[31:0]; c = w[32]; rs = sa + sb; end
            3'd1: begin w = {1'b0,a} + {1'b0,b} + {32'd0,cin}; r = w[31:0]; c = w[32];
                        rs = sa + sb + longint'(cin); end
            3'd2: begin r = a - b; c = (a < b); rs = sa - sb; end
            3'd3: r = a & b;
            3'd4: r = a | b;
            3'd5: r = a ^ b;
            default: valid = 1'b0;
        endcase
        if (op <= 3'd2) v = (rs > 64'sd2147483647) || (rs < -64'sd2147483648);
    endfunction

    function automatic string op_req(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3, 3'd4, 3'd5: return "R7";
            default: return "R9";
        endcase
    endfunction

    // one operation: drive at negedge, check result, check flags at next negedge
    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic e, input logic sf, output logic [31:0] r_seen);
        logic [31:0] r; logic v, c; bit valid; logic [3:0] nf;
        op_sel = op; src_a = a; src_b = b; en = e; set_flags = sf;
        model(op, a, b, mflags[0], r, v, c, valid);
        #1;
        r_seen = result;
        chk(op_req(op), "result", {32'd0, result}, {32'd0, r});
        nf = {r[31], (r == 32'd0), v, c};
        @(negedge clk);
        if (e && sf && valid) begin
            chk("R6", "N", {63'd0, flags[3]}, {63'd0, nf[3]});
            chk("R6", "Z", {63'd0, flags[2]}, {63'd0, nf[2]});
            chk((op <= 3'd2) ? "R5" : "R7", "V", {63'd0, flags[1]}, {63'd0, nf[1]});
            chk(op_req(op), "C", {63'd0, flags[0]}, {63'd0, nf[0]});
            mflags = nf;
        end else begin
            chk(valid ? "R8" : "R9", "flags held", {60'd0, flags}, {60'd0, mflags});
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rs;
        logic [31:0] lo, hi;
        logic [63:0] x, y;
        logic [64:0] tot;
        int k;
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1", "flags in reset", {60'd0, flags}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "flags after reset", {60'd0, flags}, 64'd0);

        // sweep over all codes, corner operand pairs, both forms, enable pattern
        k = 0;
        for (int op = 0; op < 8; op++) begin
            for (int i = 0; i < NVAL; i++) begin
                for (int j = 0; j < NVAL; j++) begin
                    for (int sf = 0; sf < 2; sf++) begin
                        k++;
                        run_op(3'(op), corner(i), corner(j), (k % 5) != 0, sf[0], rs);
                    end
                end
            end
        end

        // R3: 64-bit chained sums
        for (int t = 0; t < 6; t++) begin
            case (t)
                0: begin x = 64'hFFFF_FFFF_FFFF_FFFF; y = 64'd1; end
                1: begin x = 64'h0000_0000_FFFF_FFFF; y = 64'h0000_0000_0000_0001; end
                2: begin x = 64'h1234_5678_9ABC_DEF0; y = 64'h0FED_CBA9_8765_4321; end
                3: begin x = 64'h8000_0000_8000_0000; y = 64'h8000_0000_8000_0000; end
                4: begin x = 64'h0000_0001_0000_0000; y = 64'h0000_0000_0000_0000; end
                default: begin x = 64'h7FFF_FFFF_FFFF_FFFF; y = 64'h0000_0000_0000_0001; end
            endcase
            run_op(3'd0, x[31:0], y[31:0], 1'b1, 1'b1, lo);
            run_op(3'd1, x[63:32], y[63:32], 1'b1, 1'b1, hi);
            tot = {1'b0, x} + {1'b0, y};
            chk("R3", "64-bit sum", {hi, lo}, tot[63:0]);
            chk("R3", "64-bit carry", {63'd0, flags[0]}, {63'd0, tot[64]});
        end

        // R1: reset from a non-zero flag state
        run_op(3'd2, 32'd0, 32'd1, 1'b1, 1'b1, rs);
        rst_n = 1'b0;
        #1;
        chk("R1", "flags after mid-run reset", {60'd0, flags}, 64'd0);
        finish_run();
    end

endmodule